// File: doc/BRIEF.md
# GPIO Port with Change Interrupt

An eight-pin general-purpose I/O port controller with one register per function. For every pin, software sets the direction, picks whether an output is driven from a peripheral or from the port register, and sets that register bit. On an input pin the same register bit turns on the pull-up. Software can also mark a pin as an analog input, which blanks its digital input, and can arm a change interrupt on the pin. The pad itself is not modelled. The port drives output-enable, output-value and pull-up-enable lines toward it and receives the raw pad level.

Each pad level passes through a two-flop synchroniser before software can read it. A change detector compares each synchronised level with the level it held one cycle earlier. Any armed change sets a single pending interrupt. A pin-register read clears that interrupt. When a debugger takes the port over, the two uppermost pins stop being driven. The debugger then supplies the values read back for those pins and can see their port and direction bits.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset all configuration registers are zero, so padOe, padOut and padPu are 0 and chgIrq is 0.
- R2: A write with regWe high stores regWdata in the register picked by regSel (0 direction, 1 output source, 2 port value, 3 analog, 4 change enable; codes 5 to 7 are ignored) at the next clock edge. A direction bit of 1 sets that pin's padOe.
- R3: On an output pin, padOut follows periphOut when the output-source bit is 1 and the port bit when it is 0. On an input pin padOut is 0.
- R4: On an input pin, padPu equals the port bit. On an output pin padPu is 0, so padPu and padOe are never both high on one pin.
- R5: pinVal shows a pad level two clock edges after the level is applied (two synchroniser stages), and not earlier.
- R6: When a pin's change-enable bit is 1, a change of its synchronised level sets chgIrq one edge after pinVal changes. With the bit at 0, no interrupt is raised.
- R7: A cycle with pinRd high clears chgIrq when at least one change-enable bit is 1. When all change-enable bits are 0, pinRd leaves chgIrq unchanged.
- R8: If an armed change is detected in the same cycle as pinRd, chgIrq stays set.
- R9: A pin whose analog bit is 1 reads 0 on pinVal, and no change on that pin raises chgIrq.
- R10: While dbgEn is high, pins 6 and 7 have padOe, padOut and padPu at 0. Their pinVal bits then come from dbgPinVal (bit 0 goes to pin 6) through the same two-stage synchroniser.
- R11: dbgPortBits and dbgDirBits always show the port and direction register bits of pins 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWdata | input | 8 | Register write data |
| pinRd | input | 1 | Pin-register read strobe |
| pinVal | output | 8 | Synchronised, masked pin levels |
| chgIrq | output | 1 | Pending change interrupt |
| periphOut | input | 8 | Peripheral output values per pin |
| padIn | input | 8 | Raw pad levels |
| padOe | output | 8 | Pad output enables |
| padOut | output | 8 | Pad output values |
| padPu | output | 8 | Pad pull-up enables |
| dbgEn | input | 1 | Debugger owns pins 6 and 7 |
| dbgPinVal | input | 2 | Emulated levels for pins 6 and 7 |
| dbgPortBits | output | 2 | Port register bits of pins 6 and 7 |
| dbgDirBits | output | 2 | Direction register bits of pins 6 and 7 |

## Verification
Results fall due on three fixed schedules. Pad-drive outputs and the debug readbacks settle in the same cycle as the register edge that sets them, or as the dbgEn level that changes them. pinVal lags a pad level or an emulated level by two edges, and chgIrq lags pinVal by one more edge. The driver stamps every expected item with the cycle in which it falls due, counted from the cycle in which the stimulus was applied. The monitor compares an item only in that cycle, on the falling edge, and counts an item it reaches late as a failure. Latency checks also sample pinVal one cycle early to confirm that the value has not yet arrived.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  // Register select codes seen on regSel
  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_ALT   = 3'd1,
    SEL_PORT  = 3'd2,
    SEL_ANA   = 3'd3,
    SEL_CHGEN = 3'd4
  } regSelE;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrDir;
    logic wrAlt;
    logic wrPort;
    logic wrAna;
    logic wrChgEn;
  } ctlStrobeT;

endpackage

// File: rtl/gpio_chg_dp.sv
module gpio_chg_dp
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DBG_LO     = 6,
  parameter int DBG_PINS   = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobeT           strobe,
  input  logic [WIDTH-1:0]    wdata,
  input  logic [WIDTH-1:0]    periphOut,
  input  logic [WIDTH-1:0]    padIn,
  input  logic                dbgEn,
  input  logic [DBG_PINS-1:0] dbgPinVal,
  output logic [WIDTH-1:0]    pinVal,
  output logic [WIDTH-1:0]    padOe,
  output logic [WIDTH-1:0]    padOut,
  output logic [WIDTH-1:0]    padPu,
  output logic [DBG_PINS-1:0] dbgPortBits,
  output logic [DBG_PINS-1:0] dbgDirBits,
  output logic [WIDTH-1:0]    anaBits,
  output logic                anyChg,
  output logic                chgEnAny
);

  localparam int DBG_HI = DBG_LO + DBG_PINS - 1;

  logic [WIDTH-1:0] dirReg, altReg, portReg, anaReg, chgEnReg;
  logic [WIDTH-1:0] rawIn, owned, effVal, prevVal, chgVec;
  logic [WIDTH-1:0] syncQ [SYNC_DEPTH];

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      altReg   <= '0;
      portReg  <= '0;
      anaReg   <= '0;
      chgEnReg <= '0;
    end else begin
      if (strobe.wrDir)   dirReg   <= wdata;
      if (strobe.wrAlt)   altReg   <= wdata;
      if (strobe.wrPort)  portReg  <= wdata;
      if (strobe.wrAna)   anaReg   <= wdata;
      if (strobe.wrChgEn) chgEnReg <= wdata;
    end
  end

  // Per-pin source selection and pad drive
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= DBG_LO && i <= DBG_HI) begin : g_dbg
      assign owned[i] = dbgEn;
      assign rawIn[i] = dbgEn ? dbgPinVal[i-DBG_LO] : padIn[i];
    end else begin : g_norm
      assign owned[i] = 1'b0;
      assign rawIn[i] = padIn[i];
    end
    assign padOe[i]  = dirReg[i] & ~owned[i];
    assign padOut[i] = dirReg[i] & ~owned[i] &
                       (altReg[i] ? periphOut[i] : portReg[i]);
    assign padPu[i]  = ~dirReg[i] & portReg[i] & ~owned[i];
  end

  // Input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncQ[k] <= '0;
    end else begin
      syncQ[0] <= rawIn;
      for (int k = 1; k < SYNC_DEPTH; k++) syncQ[k] <= syncQ[k-1];
    end
  end

  assign effVal = syncQ[SYNC_DEPTH-1] & ~anaReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= effVal;
  end

  assign chgVec      = (effVal ^ prevVal) & chgEnReg & ~anaReg;
  assign anyChg      = |chgVec;
  assign chgEnAny    = |chgEnReg;
  assign pinVal      = effVal;
  assign anaBits     = anaReg;
  assign dbgPortBits = portReg[DBG_LO +: DBG_PINS];
  assign dbgDirBits  = dirReg[DBG_LO +: DBG_PINS];

endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [2:0] regSel,
  input  logic       pinRd,
  input  logic       anyChg,
  input  logic       chgEnAny,
  output ctlStrobeT  strobe,
  output logic       chgIrq
);

  logic pendQ;

  always_comb begin
    strobe = '0;
    if (regWe) begin
      case (regSelE'(regSel))
        SEL_DIR:   strobe.wrDir   = 1'b1;
        SEL_ALT:   strobe.wrAlt   = 1'b1;
        SEL_PORT:  strobe.wrPort  = 1'b1;
        SEL_ANA:   strobe.wrAna   = 1'b1;
        SEL_CHGEN: strobe.wrChgEn = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  // A fresh change outranks a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pendQ <= 1'b0;
    else if (anyChg)            pendQ <= 1'b1;
    else if (pinRd && chgEnAny) pendQ <= 1'b0;
  end

  assign chgIrq = pendQ;

endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int DBG_LO     = 6,
  parameter int DBG_PINS   = 2,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [2:0]          regSel,
  input  logic [WIDTH-1:0]    regWdata,
  input  logic                pinRd,
  output logic [WIDTH-1:0]    pinVal,
  output logic                chgIrq,
  input  logic [WIDTH-1:0]    periphOut,
  input  logic [WIDTH-1:0]    padIn,
  output logic [WIDTH-1:0]    padOe,
  output logic [WIDTH-1:0]    padOut,
  output logic [WIDTH-1:0]    padPu,
  input  logic                dbgEn,
  input  logic [DBG_PINS-1:0] dbgPinVal,
  output logic [DBG_PINS-1:0] dbgPortBits,
  output logic [DBG_PINS-1:0] dbgDirBits
);

  ctlStrobeT        strobe;
  logic             anyChg, chgEnAny;
  logic [WIDTH-1:0] anaBits;

  gpio_chg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .pinRd(pinRd),
    .anyChg(anyChg), .chgEnAny(chgEnAny), .strobe(strobe), .chgIrq(chgIrq)
  );

  gpio_chg_dp #(
    .WIDTH(WIDTH), .DBG_LO(DBG_LO), .DBG_PINS(DBG_PINS), .SYNC_DEPTH(SYNC_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(regWdata),
    .periphOut(periphOut), .padIn(padIn), .dbgEn(dbgEn), .dbgPinVal(dbgPinVal),
    .pinVal(pinVal), .padOe(padOe), .padOut(padOut), .padPu(padPu),
    .dbgPortBits(dbgPortBits), .dbgDirBits(dbgDirBits), .anaBits(anaBits),
    .anyChg(anyChg), .chgEnAny(chgEnAny)
  );

endmodule

// File: rtl/gpio_chg_chk.sv
module gpio_chg_chk #(
  parameter int WIDTH    = 8,
  parameter int DBG_LO   = 6,
  parameter int DBG_PINS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             pinRd,
  input logic             chgIrq,
  input logic             anyChg,
  input logic             chgEnAny,
  input logic             dbgEn,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padPu,
  input logic [WIDTH-1:0] pinVal,
  input logic [WIDTH-1:0] anaBits
);

  assert_oe_pu_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPu) == '0);

  assert_dbg_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    dbgEn |-> (padOe[DBG_LO +: DBG_PINS] == '0 && padPu[DBG_LO +: DBG_PINS] == '0));

  assert_ana_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pinVal & anaBits) == '0);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pinRd && chgEnAny && !anyChg) |=> !chgIrq);

  assert_change_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pinRd && anyChg) |=> chgIrq);

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chgIrq) |-> $past(anyChg));

endmodule

bind gpio_chg_port gpio_chg_chk #(
  .WIDTH(WIDTH), .DBG_LO(DBG_LO), .DBG_PINS(DBG_PINS)
) u_chk (
  .clk(clk), .rstN(rstN), .pinRd(pinRd), .chgIrq(chgIrq), .anyChg(anyChg),
  .chgEnAny(chgEnAny), .dbgEn(dbgEn), .padOe(padOe), .padPu(padPu),
  .pinVal(pinVal), .anaBits(anaBits)
);

// File: tb/sim_gpio_chg_port.sv
module sim_gpio_chg_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regSel = '0;
  logic [7:0] regWdata = '0;
  logic       pinRd = 1'b0;
  logic [7:0] pinVal;
  logic       chgIrq;
  logic [7:0] periphOut = '0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPu;
  logic       dbgEn = 1'b0;
  logic [1:0] dbgPinVal = '0;
  logic [1:0] dbgPortBits, dbgDirBits;

  gpio_chg_port u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .pinRd(pinRd), .pinVal(pinVal), .chgIrq(chgIrq), .periphOut(periphOut),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPu(padPu),
    .dbgEn(dbgEn), .dbgPinVal(dbgPinVal), .dbgPortBits(dbgPortBits),
    .dbgDirBits(dbgDirBits)
  );

  always #10 clk = ~clk;

  localparam int S_OE = 0, S_OUT = 1, S_PU = 2, S_PIN = 3, S_IRQ = 4,
                 S_DPORT = 5, S_DDIR = 6;

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] exp;
    string      req;
  } expT;

  expT q[$];
  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pick(int sig);
    case (sig)
      S_OE:    return padOe;
      S_OUT:   return padOut;
      S_PU:    return padPu;
      S_PIN:   return pinVal;
      S_IRQ:   return {7'd0, chgIrq};
      S_DPORT: return {6'd0, dbgPortBits};
      default: return {6'd0, dbgDirBits};
    endcase
  endfunction

  // Monitor: compares each item in the cycle it falls due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      expT it;
      logic [7:0] act;
      it  = q.pop_front();
      act = pick(it.sig);
      total++;
      if (it.due < cyc || act !== it.exp) begin
        bad++;
        $display("FAIL %s sig=%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic expectAt(int dly, int sig, logic [7:0] val, string req);
    expT it;
    it.due = cyc + dly;
    it.sig = sig;
    it.exp = val;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
  endtask

  task automatic wr(logic [2:0] sel, logic [7:0] data);
    tick();
    regWe = 1'b1; regSel = sel; regWdata = data;
    tick();
    regWe = 1'b0;
  endtask

  task automatic readPulse();
    tick();
    pinRd = 1'b1;
    tick();
    pinRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R1 reset state
    expectAt(1, S_OE, 8'h00, "R1");
    expectAt(1, S_OUT, 8'h00, "R1");
    expectAt(1, S_PU, 8'h00, "R1");
    expectAt(1, S_PIN, 8'h00, "R1");
    expectAt(1, S_IRQ, 8'h00, "R1");
    drain();

    // R2 R3 R4: direction F0, port A5
    wr(3'd0, 8'hF0);
    wr(3'd2, 8'hA5);
    wr(3'd6, 8'hFF);           // unused code, R2 says ignored
    expectAt(1, S_OE, 8'hF0, "R2");
    expectAt(1, S_OUT, 8'hA0, "R3");
    expectAt(1, S_PU, 8'h05, "R4");
    drain();

    // R3 peripheral source on pins 4,5
    tick();
    periphOut = 8'h10;
    wr(3'd1, 8'h30);
    expectAt(1, S_OUT, 8'h90, "R3");
    drain();

    // R5 latency, R6 no enable no interrupt
    tick();
    padIn = 8'h3C;
    expectAt(1, S_PIN, 8'h00, "R5");
    expectAt(2, S_PIN, 8'h3C, "R5");
    expectAt(3, S_IRQ, 8'h00, "R6");
    drain();

    // R6 armed change
    wr(3'd4, 8'hFF);
    tick();
    padIn = 8'h3D;
    expectAt(2, S_PIN, 8'h3D, "R6");
    expectAt(3, S_IRQ, 8'h01, "R6");
    drain();

    // R7 read clears
    readPulse();
    expectAt(1, S_IRQ, 8'h00, "R7");
    drain();

    // R8 change and read land on the same edge
    tick();
    padIn = 8'h3C;
    tick();
    tick();
    pinRd = 1'b1;
    tick();
    pinRd = 1'b0;
    expectAt(1, S_IRQ, 8'h01, "R8");
    drain();
    readPulse();
    expectAt(1, S_IRQ, 8'h00, "R7");
    drain();

    // R9 analog on low nibble
    wr(3'd3, 8'h0F);
    expectAt(1, S_PIN, 8'h30, "R9");
    expectAt(2, S_IRQ, 8'h00, "R9");
    drain();
    tick();
    padIn = 8'h3D;
    expectAt(2, S_PIN, 8'h30, "R9");
    expectAt(3, S_IRQ, 8'h00, "R9");
    drain();

    // R10 R11 debugger takes pins 6,7
    tick();
    dbgEn = 1'b1;
    dbgPinVal = 2'b10;
    expectAt(1, S_OE, 8'h30, "R10");
    expectAt(1, S_OUT, 8'h10, "R10");
    expectAt(1, S_DPORT, 8'h02, "R11");
    expectAt(1, S_DDIR, 8'h03, "R11");
    expectAt(2, S_PIN, 8'hB0, "R10");
    expectAt(3, S_IRQ, 8'h01, "R10");
    drain();
    wr(3'd0, 8'h00);
    expectAt(1, S_PU, 8'h25, "R10");
    expectAt(1, S_DDIR, 8'h00, "R11");
    drain();

    // R7 read with no enables leaves the interrupt pending
    wr(3'd4, 8'h00);
    readPulse();
    expectAt(1, S_IRQ, 8'h01, "R7");
    drain();
    wr(3'd4, 8'hFF);
    readPulse();
    expectAt(1, S_IRQ, 8'h00, "R7");
    drain();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule